// File: doc/BRIEF.md
# Interleaved Lane Shift Array with Selectable Lane Count

This block is a 96-stage serial loading register that feeds a downstream display latch. Its stages are split into interleaved lanes, so lane k owns stages k, k+N, k+2N and so on, with N the lane count. A static mode input chooses either six lanes of 16 stages each or three lanes of 32 stages each. Every lane advances by one position (N stages) on each falling edge of the shift clock.

A direction input picks the way data travels. Each lane has two edge pin groups, A (the low end) and B (the high end), and their roles swap with the direction. When shifting right, A loads the lowest stages and B presents the highest stages. When shifting left, B loads the highest stages and A presents the lowest. Tristate pins are modelled as separate input, output and output-enable signals. All 96 stage values are presented in parallel on one bus, for capture by a latch that sits outside this block.

Top module: `lane_shift_array`

## Requirements
- R1: The stage contents change only on a falling edge of `clk`; a rising edge leaves `stages` unchanged.
- R2: Six-lane mode (`narrow_mode`=0) with `dir_right`=1: on each falling edge, stage i+6 takes the old stage i, and stages S1..S6 take `a_in[0]`..`a_in[5]`.
- R3: Three-lane mode (`narrow_mode`=1) with `dir_right`=1: on each falling edge, stage i+3 takes the old stage i, stages S1..S3 take `a_in[0]`..`a_in[2]`, and `a_in[5:3]` has no effect.
- R4: Six-lane mode with `dir_right`=0: on each falling edge, stage i takes the old stage i+6, and stages S91..S96 take `b_in[0]`..`b_in[5]`.
- R5: Three-lane mode with `dir_right`=0: on each falling edge, stage i takes the old stage i+3, stages S94..S96 take `b_in[0]`..`b_in[2]`, and `b_in[5:3]` has no effect.
- R6: `b_out[k]` shows stage S(91+k) in six-lane mode. In three-lane mode, `b_out[k]` shows S(94+k) for k<3, and `b_out[5:3]` is 0.
- R7: `a_out[k]` shows stage S(k+1) for every lane in use. In three-lane mode, `a_out[5:3]` is 0.
- R8: `b_oe` equals `dir_right`, `a_oe` equals its inverse, and the two are never equal.
- R9: Whichever group is acting as output has its inputs ignored: `b_in` has no effect when shifting right, and `a_in` has no effect when shifting left.
- R10: A change of `narrow_mode` takes effect at the next falling edge and does not clear the stored stages.
- R11: `rst` high at a falling edge clears all 96 stages to 0.
- R12: `stages[i]` carries stage S(i+1), so bit 0 is S1 and bit 95 is S96.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock; the stages update on its falling edge |
| rst | input | 1 | Synchronous clear, active high, sampled on the falling edge |
| narrow_mode | input | 1 | 1: three lanes of 32 stages; 0: six lanes of 16 stages |
| dir_right | input | 1 | 1: shift toward higher stages; 0: shift toward lower stages |
| a_in | input | 6 | Low-end serial data for each lane, used when shifting right |
| a_out | output | 6 | Low-end stage values for each lane |
| a_oe | output | 1 | Drive enable for the A group; high when shifting left |
| b_in | input | 6 | High-end serial data for each lane, used when shifting left |
| b_out | output | 6 | High-end stage values for each lane |
| b_oe | output | 1 | Drive enable for the B group; high when shifting right |
| stages | output | 96 | Parallel view of all stages, bit i = S(i+1) |

## Verification
A corrupt stage shows up at once on the `stages` bus after the falling edge that wrote it. It reaches the serial edge outputs only after it has moved to the end of its lane, which takes up to 16 edges in six-lane mode and up to 32 in three-lane mode. A wrong interleave or stride, such as shifting by 3 while in six-lane mode, puts bits into the wrong lanes. This is visible one edge after the bits are loaded, so the bench compares the full 96-bit image after every falling edge rather than only the edge pins. A mode switch that clears or reorders the stages would show up as a mismatch at the very next edge.

// File: rtl/lsa_pkg.sv
`timescale 1ns/1ps
package lsa_pkg;
   // default geometry of the array
   localparam int unsigned DEF_STAGES = 96;
   localparam int unsigned DEF_WIDE   = 6;
   localparam int unsigned DEF_NARROW = 3;

   // index of each lane-count variant in the candidate table
   typedef enum logic {
      VAR_WIDE   = 1'b0,
      VAR_NARROW = 1'b1
   } lane_var_e;

   localparam int unsigned NUM_VARIANTS = 2;

   // first stage index of the top group for a given lane count
   function automatic int unsigned top_base(input int unsigned stages,
                                            input int unsigned lanes);
      return stages - lanes;
   endfunction
endpackage

// File: rtl/lsa_next_state.sv
`timescale 1ns/1ps
module lsa_next_state #(
   parameter int unsigned STAGES = lsa_pkg::DEF_STAGES,
   parameter int unsigned LANES  = lsa_pkg::DEF_WIDE
) (
   input  logic [STAGES-1:0] cur,
   input  logic              dir_right,
   input  logic [LANES-1:0]  a_lane,
   input  logic [LANES-1:0]  b_lane,
   output logic [STAGES-1:0] nxt
);
   localparam int unsigned DEPTH = STAGES / LANES;
   localparam int unsigned KEEP  = STAGES - LANES;

   initial begin
      assert (STAGES % LANES == 0)
         else $error("lsa_next_state: STAGES must divide evenly by LANES");
      assert (DEPTH >= 2)
         else $error("lsa_next_state: each lane needs at least two stages");
   end

   // one lane step equals a stride of LANES across the flat stage vector
   always_comb begin
      if (dir_right) begin
         nxt = {cur[KEEP-1:0], a_lane};
      end else begin
         nxt = {b_lane, cur[STAGES-1:LANES]};
      end
   end
endmodule

// File: rtl/lsa_shift_core.sv
`timescale 1ns/1ps
module lsa_shift_core #(
   parameter int unsigned STAGES = lsa_pkg::DEF_STAGES,
   parameter int unsigned WIDE   = lsa_pkg::DEF_WIDE,
   parameter int unsigned NARROW = lsa_pkg::DEF_NARROW
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              narrow_mode,
   input  logic              dir_right,
   input  logic [WIDE-1:0]   a_in,
   input  logic [WIDE-1:0]   b_in,
   output logic [STAGES-1:0] stage_q
);
   import lsa_pkg::*;

   logic [STAGES-1:0] cand [NUM_VARIANTS];
   logic [STAGES-1:0] chosen;
   logic              hist_ok;

   // one next-state generator per lane-count variant
   for (genvar v = 0; v < NUM_VARIANTS; v++) begin : g_var
      localparam int unsigned LN = (v == int'(VAR_WIDE)) ? WIDE : NARROW;
      lsa_next_state #(
         .STAGES(STAGES),
         .LANES (LN)
      ) u_next (
         .cur      (stage_q),
         .dir_right(dir_right),
         .a_lane   (a_in[LN-1:0]),
         .b_lane   (b_in[LN-1:0]),
         .nxt      (cand[v])
      );
   end

   always_comb begin
      chosen = narrow_mode ? cand[VAR_NARROW] : cand[VAR_WIDE];
   end

   always_ff @(negedge clk) begin
      if (rst) begin
         stage_q <= '0;
         hist_ok <= 1'b0;
      end else begin
         stage_q <= chosen;
         hist_ok <= 1'b1;
      end
   end

   // R2
   right_wide_chk: assert property (@(negedge clk) disable iff (rst)
      (hist_ok && $past(dir_right) && !$past(narrow_mode)) |->
      (stage_q[STAGES-1:WIDE] == $past(stage_q[STAGES-WIDE-1:0]) &&
       stage_q[WIDE-1:0] == $past(a_in)));

   // R3
   right_narrow_chk: assert property (@(negedge clk) disable iff (rst)
      (hist_ok && $past(dir_right) && $past(narrow_mode)) |->
      (stage_q[STAGES-1:NARROW] == $past(stage_q[STAGES-NARROW-1:0]) &&
       stage_q[NARROW-1:0] == $past(a_in[NARROW-1:0])));

   // R4
   left_wide_chk: assert property (@(negedge clk) disable iff (rst)
      (hist_ok && !$past(dir_right) && !$past(narrow_mode)) |->
      (stage_q[STAGES-WIDE-1:0] == $past(stage_q[STAGES-1:WIDE]) &&
       stage_q[STAGES-1:STAGES-WIDE] == $past(b_in)));

   // R5
   left_narrow_chk: assert property (@(negedge clk) disable iff (rst)
      (hist_ok && !$past(dir_right) && $past(narrow_mode)) |->
      (stage_q[STAGES-NARROW-1:0] == $past(stage_q[STAGES-1:NARROW]) &&
       stage_q[STAGES-1:STAGES-NARROW] == $past(b_in[NARROW-1:0])));
endmodule

// File: rtl/lsa_edge_io.sv
`timescale 1ns/1ps
module lsa_edge_io #(
   parameter int unsigned WIDE   = lsa_pkg::DEF_WIDE,
   parameter int unsigned NARROW = lsa_pkg::DEF_NARROW
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            narrow_mode,
   input  logic            dir_right,
   input  logic [WIDE-1:0] low_s,   // stages S1..S(WIDE)
   input  logic [WIDE-1:0] high_s,  // top WIDE stages, lowest first
   output logic [WIDE-1:0] a_out,
   output logic [WIDE-1:0] b_out,
   output logic            a_oe,
   output logic            b_oe
);
   localparam int unsigned SKIP = WIDE - NARROW;

   for (genvar k = 0; k < WIDE; k++) begin : g_pin
      if (k < NARROW) begin : g_shared
         // lane used in both modes; narrow mode takes the topmost stages
         always_comb begin
            a_out[k] = low_s[k];
            b_out[k] = narrow_mode ? high_s[k+SKIP] : high_s[k];
         end
      end else begin : g_wide_only
         always_comb begin
            a_out[k] = narrow_mode ? 1'b0 : low_s[k];
            b_out[k] = narrow_mode ? 1'b0 : high_s[k];
         end
      end
   end

   always_comb begin
      b_oe = dir_right;
      a_oe = ~dir_right;
   end

   // R8
   oe_excl_chk: assert property (@(negedge clk) disable iff (rst)
      a_oe ^ b_oe);

   // R6
   b_wide_chk: assert property (@(negedge clk) disable iff (rst)
      !narrow_mode |-> (b_out == high_s));

   // R7
   unused_low_chk: assert property (@(negedge clk) disable iff (rst)
      narrow_mode |-> (a_out[WIDE-1:NARROW] == '0 && b_out[WIDE-1:NARROW] == '0));
endmodule

// File: rtl/lane_shift_array.sv
`timescale 1ns/1ps
module lane_shift_array #(
   parameter int unsigned STAGES = lsa_pkg::DEF_STAGES,
   parameter int unsigned WIDE   = lsa_pkg::DEF_WIDE,
   parameter int unsigned NARROW = lsa_pkg::DEF_NARROW
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              narrow_mode,
   input  logic              dir_right,
   input  logic [WIDE-1:0]   a_in,
   output logic [WIDE-1:0]   a_out,
   output logic              a_oe,
   input  logic [WIDE-1:0]   b_in,
   output logic [WIDE-1:0]   b_out,
   output logic              b_oe,
   output logic [STAGES-1:0] stages
);
   localparam int unsigned HI_BASE = lsa_pkg::top_base(STAGES, WIDE);

   initial begin
      assert (NARROW < WIDE)
         else $error("lane_shift_array: NARROW must be below WIDE");
      assert (NARROW > 0)
         else $error("lane_shift_array: NARROW must be nonzero");
      assert (STAGES % WIDE == 0 && STAGES % NARROW == 0)
         else $error("lane_shift_array: STAGES must divide by both lane counts");
   end

   logic [STAGES-1:0] stage_q;

   lsa_shift_core #(
      .STAGES(STAGES),
      .WIDE  (WIDE),
      .NARROW(NARROW)
   ) u_core (
      .clk        (clk),
      .rst        (rst),
      .narrow_mode(narrow_mode),
      .dir_right  (dir_right),
      .a_in       (a_in),
      .b_in       (b_in),
      .stage_q    (stage_q)
   );

   lsa_edge_io #(
      .WIDE  (WIDE),
      .NARROW(NARROW)
   ) u_edge (
      .clk        (clk),
      .rst        (rst),
      .narrow_mode(narrow_mode),
      .dir_right  (dir_right),
      .low_s      (stage_q[WIDE-1:0]),
      .high_s     (stage_q[HI_BASE +: WIDE]),
      .a_out      (a_out),
      .b_out      (b_out),
      .a_oe       (a_oe),
      .b_oe       (b_oe)
   );

   assign stages = stage_q;
endmodule

// File: tb/lane_shift_array_tb_top.sv
`timescale 1ns/1ps
module lane_shift_array_tb_top;
   localparam int S = 96;
   localparam int W = 6;
   localparam int N = 3;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic narrow_mode = 1'b0;
   logic dir_right = 1'b1;
   logic [W-1:0] a_in = '0;
   logic [W-1:0] b_in = '0;
   logic [W-1:0] a_out, b_out;
   logic a_oe, b_oe;
   logic [S-1:0] stages;

   logic [S-1:0] model = '0;
   int checks = 0;
   int fails = 0;

   always #2.5 clk = ~clk;

   lane_shift_array dut_i (
      .clk(clk), .rst(rst), .narrow_mode(narrow_mode), .dir_right(dir_right),
      .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
      .b_in(b_in), .b_out(b_out), .b_oe(b_oe), .stages(stages)
   );

   function automatic int lanes();
      return narrow_mode ? N : W;
   endfunction

   task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic model_update();
      logic [S-1:0] nx;
      int n;
      n = lanes();
      if (rst) nx = '0;
      else if (dir_right) begin
         for (int i = 0; i < S; i++) nx[i] = (i < n) ? a_in[i] : model[i-n];
      end else begin
         for (int i = 0; i < S; i++) nx[i] = (i >= S-n) ? b_in[i-(S-n)] : model[i+n];
      end
      model = nx;
   endtask

   task automatic check_all(input string tag);
      logic [W-1:0] ea, eb;
      int n;
      n = lanes();
      for (int k = 0; k < W; k++) begin
         ea[k] = (k < n) ? model[k] : 1'b0;
         eb[k] = (k < n) ? model[S-n+k] : 1'b0;
      end
      chk({tag, " stages R12"}, 128'(stages), 128'(model));
      chk({tag, " a_out R7"}, 128'(a_out), 128'(ea));
      chk({tag, " b_out R6"}, 128'(b_out), 128'(eb));
      chk({tag, " enables R8"}, 128'({a_oe, b_oe}), 128'({~dir_right, dir_right}));
   endtask

   // inputs are set one ns after a falling edge; the next falling edge is 5 ns later
   task automatic step(input string tag);
      @(negedge clk);
      #1;
      model_update();
      check_all(tag);
   endtask

   task automatic t_reset();
      rst = 1'b1;
      step("R11 reset");
      step("R11 reset");
      rst = 1'b0;
   endtask

   task automatic t_right_wide();
      narrow_mode = 1'b0; dir_right = 1'b1;
      for (int i = 0; i < 20; i++) begin
         a_in = W'($urandom); b_in = W'($urandom);
         step("R2 right six-lane");
      end
   endtask

   task automatic t_right_narrow();
      narrow_mode = 1'b1; dir_right = 1'b1;
      for (int i = 0; i < 36; i++) begin
         a_in = W'($urandom) | 6'b111000; b_in = W'($urandom);
         step("R3 right three-lane");
      end
   endtask

   task automatic t_left_wide();
      narrow_mode = 1'b0; dir_right = 1'b0;
      for (int i = 0; i < 20; i++) begin
         a_in = W'($urandom); b_in = W'($urandom);
         step("R4 left six-lane");
      end
   endtask

   task automatic t_left_narrow();
      narrow_mode = 1'b1; dir_right = 1'b0;
      for (int i = 0; i < 36; i++) begin
         a_in = W'($urandom); b_in = W'($urandom) | 6'b111000;
         step("R5 left three-lane");
      end
   endtask

   task automatic t_ignore();
      narrow_mode = 1'b0; dir_right = 1'b1; a_in = 6'h2A;
      for (int i = 0; i < 6; i++) begin
         b_in = W'(i * 11);
         step("R9 b_in ignored on right");
      end
      dir_right = 1'b0; b_in = 6'h15;
      for (int i = 0; i < 6; i++) begin
         a_in = W'(i * 13);
         step("R9 a_in ignored on left");
      end
   endtask

   task automatic t_mode_switch();
      narrow_mode = 1'b0; dir_right = 1'b1;
      for (int i = 0; i < 8; i++) begin
         a_in = W'($urandom);
         step("R10 fill before switch");
      end
      narrow_mode = 1'b1; a_in = 6'h05;
      step("R10 first edge after switch");
      narrow_mode = 1'b0; dir_right = 1'b0; b_in = 6'h3F;
      step("R10 switch back with left");
   endtask

   task automatic t_rising();
      narrow_mode = 1'b0; dir_right = 1'b1; a_in = 6'h33;
      step("R1 shift");
      @(posedge clk);
      #1;
      chk("R1 no change at rising edge", 128'(stages), 128'(model));
   endtask

   task automatic t_travel();
      rst = 1'b1; step("R11 clear before travel"); rst = 1'b0;
      narrow_mode = 1'b0; dir_right = 1'b1; a_in = 6'h01;
      step("R2 single bit load");
      a_in = '0;
      for (int i = 0; i < 15; i++) step("R2 single bit travel");
      chk("R12 bit lands at S91", 128'(stages), 128'(96'b1 << 90));
      chk("R6 b_out lane0 shows S91", 128'(b_out), 128'(6'h01));
   endtask

   task automatic t_mid_reset();
      narrow_mode = 1'b1; dir_right = 1'b1;
      for (int i = 0; i < 4; i++) begin a_in = 6'h07; step("R3 fill"); end
      rst = 1'b1;
      step("R11 mid-run clear");
      chk("R11 all stages zero", 128'(stages), 128'(0));
      rst = 1'b0;
   endtask

   initial begin
      t_reset();
      t_right_wide();
      t_right_narrow();
      t_left_wide();
      t_left_narrow();
      t_ignore();
      t_mode_switch();
      t_rising();
      t_travel();
      t_mid_reset();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(200000 * 5);
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule